// File: doc/BRIEF.md
# Hierarchical Coherence Directory Node

This block is one filter node in a tree of buses. It sits between a lower bus, which leads to the subsystem below it, and a higher bus, which leads toward the root. It keeps a two-way set-associative memory of tags and coherence states only. It never stores line data. For every read, erase, data-reply or acknowledge transaction seen on either side, the node decides whether to pass it upward, pass it downward, answer it locally, drop it, or send back a retry.

Each stable state tells whether a line lives somewhere below the node:
- **shared**: the line is below, and copies may also exist elsewhere in the tree.
- **exclusive**: every copy is below.
- **invalid**: the line is not below.

Searches in flight leave transient marks that route their replies:
- **reading-up**: a read from below is waiting for data from above.
- **reading-down**: a read from above was steered into the subsystem.
- **erasing**: an erase from below is waiting for its acknowledge.

When all copies of a line are covered by this node, an erase from below is acknowledged at once. The node does not ask each holder.

A line is 16 bytes. The set index is taken from the address bits just above the line offset, and the tag is the rest of the address. Each set keeps one recency bit. A set full of live lines gives up its older way by first pushing that line upward.

Top module: `dir_node`

## Requirements
- R1: Transaction codes are read=1, erase=2, data=3, ack=4 and push-out=5. Reset leaves every entry invalid and all four outputs idle. The set index is address bits [OFFS+IDX-1:OFFS], with OFFS=4.
- R2: A read from below that misses allocates the line as reading-up and appears on the up port one cycle later, with the same code and address. The up and down ports are never valid together.
- R3: A read from below to a line in reading-up is combined with the pending one and produces no output.
- R4: Data from above for a reading-up line goes down and leaves the line shared. A later read from below to that line is filtered.
- R5: A read from above to a line present below goes down and marks it reading-down. Data from below for that line then goes up and leaves it shared. A read from above to an absent line is filtered. Only traffic from below ever produces output on the up port.
- R6: An erase from below to a shared line goes up and marks it erasing. An ack from above then goes down and makes the line exclusive. An erase from below to an exclusive line is acknowledged downward at once, with nothing sent up.
- R7: An erase from above to a line present below goes down and invalidates the entry, so a following read from above is filtered.
- R8: A conflicting transaction that hits a transient entry is answered with a retry to the side it came from, one cycle later, and is not forwarded.
- R9: When both sides present a transaction in the same cycle, the upper one is processed and the lower one is retried.
- R10: A miss from below into a set whose two ways hold live lines sends push-out upward with the victim's line address and retries the requester. The retried request is then allocated and forwarded.
- R11: The victim is the way not touched most recently in that set. An invalid way is taken before any live way.
- R12: Data or ack that finds no matching transient entry is dropped, with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_vld | input | 1 | Transaction from the lower bus is valid |
| lo_op | input | 3 | Code of the lower-bus transaction |
| lo_addr | input | ADDR_W | Byte address of the lower-bus transaction |
| hi_vld | input | 1 | Transaction from the higher bus is valid |
| hi_op | input | 3 | Code of the higher-bus transaction |
| hi_addr | input | ADDR_W | Byte address of the higher-bus transaction |
| up_vld | output | 1 | Transaction issued toward the higher bus |
| up_op | output | 3 | Code issued upward |
| up_addr | output | ADDR_W | Address issued upward |
| dn_vld | output | 1 | Transaction issued toward the lower bus |
| dn_op | output | 3 | Code issued downward |
| dn_addr | output | ADDR_W | Address issued downward |
| lo_retry | output | 1 | Lower-side transaction of the previous cycle must be repeated |
| hi_retry | output | 1 | Upper-side transaction of the previous cycle must be repeated |

## Verification
The bench builds the node with four sets and a 16-bit address. With so few sets, three lines that share index 0 fill a set after only a few transactions. That brings eviction, the push-out and retry step, and the recency choice into reach. One line is then walked through every state, on both the up and down paths, and meets a conflicting request at each transient stage. Same-cycle arbitration between the two sides and stray replies are also exercised.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_ER   = 3'd2,
    OP_DATA = 3'd3,
    OP_ACK  = 3'd4,
    OP_OUT  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_SHR = 3'd1,
    ST_EXC = 3'd2,
    ST_RDU = 3'd3,
    ST_RDD = 3'd4,
    ST_ERS = 3'd5
  } st_e;

  function automatic logic is_present(st_e s);
    return (s == ST_SHR) || (s == ST_EXC);
  endfunction

  function automatic logic is_transient(st_e s);
    return (s == ST_RDU) || (s == ST_RDD) || (s == ST_ERS);
  endfunction
endpackage

// File: rtl/dir_state_mem.sv
module dir_state_mem #(
  parameter int SETS  = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [IDX_W-1:0]                       rd_idx,
  output logic [dir_pkg::WAYS-1:0][TAG_W-1:0]    rd_tag,
  output dir_pkg::st_e [dir_pkg::WAYS-1:0]       rd_st,
  output logic                                   rd_lru,
  input  logic                                   wr_en,
  input  logic [IDX_W-1:0]                       wr_idx,
  input  logic                                   wr_way,
  input  logic [TAG_W-1:0]                       wr_tag,
  input  dir_pkg::st_e                           wr_st,
  input  logic                                   lru_en,
  input  logic                                   lru_val
);
  import dir_pkg::*;

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    st_e              st_q  [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) tag_q[wr_idx] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= ST_INV;
      end else if (wr_en && (wr_way == w[0])) begin
        st_q[wr_idx] <= wr_st;
      end
    end

    assign rd_tag[w] = tag_q[rd_idx];
    assign rd_st[w]  = st_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         lru_q         <= '0;
    else if (lru_en) lru_q[wr_idx] <= lru_val;
  end

  assign rd_lru = lru_q[rd_idx];
endmodule

// File: rtl/dir_lookup.sv
module dir_lookup #(
  parameter int TAG_W = 24
) (
  input  logic [dir_pkg::WAYS-1:0][TAG_W-1:0] tags,
  input  dir_pkg::st_e [dir_pkg::WAYS-1:0]    sts,
  input  logic [TAG_W-1:0]                    req_tag,
  output logic                                hit,
  output logic                                hit_way,
  output dir_pkg::st_e                        hit_st
);
  import dir_pkg::*;

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (sts[w] != ST_INV) && (tags[w] == req_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = match[1];
    hit_st  = match[1] ? sts[1] : sts[0];
  end
endmodule

// File: rtl/dir_victim.sv
module dir_victim (
  input  dir_pkg::st_e [dir_pkg::WAYS-1:0] sts,
  input  logic                             lru,
  output logic                             v_way,
  output dir_pkg::st_e                     v_st
);
  import dir_pkg::*;

  always_comb begin
    if (sts[0] == ST_INV)      v_way = 1'b0;
    else if (sts[1] == ST_INV) v_way = 1'b1;
    else                       v_way = lru;
    v_st = v_way ? sts[1] : sts[0];
  end
endmodule

// File: rtl/dir_node.sv
module dir_node #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16,
  localparam int OFFS_W = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFFS_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_vld,
  input  logic [2:0]        lo_op,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic              hi_vld,
  input  logic [2:0]        hi_op,
  input  logic [ADDR_W-1:0] hi_addr,
  output logic              up_vld,
  output logic [2:0]        up_op,
  output logic [ADDR_W-1:0] up_addr,
  output logic              dn_vld,
  output logic [2:0]        dn_op,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              lo_retry,
  output logic              hi_retry
);
  import dir_pkg::*;

  // Request selection: the upper side wins a same-cycle collision.
  logic              from_hi;
  op_e               req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;

  assign from_hi  = hi_vld;
  assign req_op   = op_e'(from_hi ? hi_op : lo_op);
  assign req_addr = from_hi ? hi_addr : lo_addr;
  assign req_idx  = req_addr[OFFS_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  st_e [WAYS-1:0]             set_st;
  logic                       set_lru;
  logic                       wr_en, wr_way, lru_en, lru_val;
  st_e                        wr_st;

  dir_state_mem #(.SETS(SETS), .TAG_W(TAG_W)) u_mem (
    .clk(clk), .rst(rst),
    .rd_idx(req_idx), .rd_tag(set_tag), .rd_st(set_st), .rd_lru(set_lru),
    .wr_en(wr_en), .wr_idx(req_idx), .wr_way(wr_way), .wr_tag(req_tag),
    .wr_st(wr_st), .lru_en(lru_en), .lru_val(lru_val)
  );

  logic hit, hit_way;
  st_e  hit_st;

  dir_lookup #(.TAG_W(TAG_W)) u_lookup (
    .tags(set_tag), .sts(set_st), .req_tag(req_tag),
    .hit(hit), .hit_way(hit_way), .hit_st(hit_st)
  );

  logic v_way;
  st_e  v_st;

  dir_victim u_victim (.sts(set_st), .lru(set_lru), .v_way(v_way), .v_st(v_st));

  logic [ADDR_W-1:0] victim_addr;
  assign victim_addr = {set_tag[v_way], req_idx, {OFFS_W{1'b0}}};

  logic              n_up_vld, n_dn_vld, n_lo_retry, n_hi_retry;
  op_e               n_up_op, n_dn_op;
  logic [ADDR_W-1:0] n_up_addr;

  always_comb begin
    n_up_vld   = 1'b0;
    n_up_op    = OP_NONE;
    n_up_addr  = req_addr;
    n_dn_vld   = 1'b0;
    n_dn_op    = OP_NONE;
    n_lo_retry = lo_vld && hi_vld;
    n_hi_retry = 1'b0;
    wr_en      = 1'b0;
    wr_way     = hit_way;
    wr_st      = ST_INV;
    lru_en     = 1'b0;
    lru_val    = ~hit_way;

    if (from_hi) begin
      unique case (req_op)
        OP_RD: if (hit) begin
          if (is_present(hit_st)) begin
            n_dn_vld = 1'b1; n_dn_op = OP_RD;
            wr_en = 1'b1; wr_st = ST_RDD; lru_en = 1'b1;
          end else if (hit_st != ST_RDD) begin
            n_hi_retry = 1'b1;
          end
        end
        OP_ER: if (hit) begin
          if (is_present(hit_st)) begin
            n_dn_vld = 1'b1; n_dn_op = OP_ER;
            wr_en = 1'b1; wr_st = ST_INV;
          end else begin
            n_hi_retry = 1'b1;
          end
        end
        OP_DATA: if (hit && hit_st == ST_RDU) begin
          n_dn_vld = 1'b1; n_dn_op = OP_DATA;
          wr_en = 1'b1; wr_st = ST_SHR; lru_en = 1'b1;
        end
        OP_ACK: if (hit && hit_st == ST_ERS) begin
          n_dn_vld = 1'b1; n_dn_op = OP_ACK;
          wr_en = 1'b1; wr_st = ST_EXC; lru_en = 1'b1;
        end
        default: ;
      endcase
    end else if (lo_vld) begin
      unique case (req_op)
        OP_RD, OP_ER: begin
          if (hit) begin
            lru_en = 1'b1;
            if (req_op == OP_RD) begin
              if (hit_st == ST_ERS) n_lo_retry = 1'b1;
            end else if (hit_st == ST_EXC) begin
              n_dn_vld = 1'b1; n_dn_op = OP_ACK;
            end else if (hit_st == ST_SHR) begin
              n_up_vld = 1'b1; n_up_op = OP_ER;
              wr_en = 1'b1; wr_st = ST_ERS;
            end else begin
              n_lo_retry = 1'b1;
            end
          end else if (is_present(v_st)) begin
            n_up_vld = 1'b1; n_up_op = OP_OUT; n_up_addr = victim_addr;
            wr_en = 1'b1; wr_way = v_way; wr_st = ST_INV;
            n_lo_retry = 1'b1;
          end else if (is_transient(v_st)) begin
            n_lo_retry = 1'b1;
          end else begin
            n_up_vld = 1'b1; n_up_op = req_op;
            wr_en = 1'b1; wr_way = v_way;
            wr_st = (req_op == OP_RD) ? ST_RDU : ST_ERS;
            lru_en = 1'b1; lru_val = ~v_way;
          end
        end
        OP_DATA: if (hit && hit_st == ST_RDD) begin
          n_up_vld = 1'b1; n_up_op = OP_DATA;
          wr_en = 1'b1; wr_st = ST_SHR; lru_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_vld   <= 1'b0;
      up_op    <= OP_NONE;
      up_addr  <= '0;
      dn_vld   <= 1'b0;
      dn_op    <= OP_NONE;
      dn_addr  <= '0;
      lo_retry <= 1'b0;
      hi_retry <= 1'b0;
    end else begin
      up_vld   <= n_up_vld;
      up_op    <= n_up_op;
      up_addr  <= n_up_addr;
      dn_vld   <= n_dn_vld;
      dn_op    <= n_dn_op;
      dn_addr  <= req_addr;
      lo_retry <= n_lo_retry;
      hi_retry <= n_hi_retry;
    end
  end
endmodule

// File: rtl/dir_node_chk.sv
module dir_node_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lo_vld,
  input logic [2:0]        lo_op,
  input logic              hi_vld,
  input logic [2:0]        hi_op,
  input logic              up_vld,
  input logic [2:0]        up_op,
  input logic              dn_vld,
  input logic [2:0]        dn_op,
  input logic              lo_retry,
  input logic              hi_retry
);
  import dir_pkg::*;

  // R2: one direction per processed transaction
  a_r2_single_direction: assert property (@(posedge clk) disable iff (rst)
    !(up_vld && dn_vld));

  // R9: collision retries the lower side
  a_r9_lower_retried: assert property (@(posedge clk) disable iff (rst)
    (lo_vld && hi_vld) |=> lo_retry);

  // R5: upward traffic only originates below
  a_r5_up_from_below: assert property (@(posedge clk) disable iff (rst)
    up_vld |-> $past(lo_vld && !hi_vld));

  // R10: a push-out always comes with a retry of the requester
  a_r10_pushout_retry: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_op == OP_OUT) |-> lo_retry);

  // R6: a downward ack follows an upper ack or a lower erase
  a_r6_ack_source: assert property (@(posedge clk) disable iff (rst)
    (dn_vld && dn_op == OP_ACK) |->
      $past((hi_vld && hi_op == OP_ACK) || (lo_vld && !hi_vld && lo_op == OP_ER)));

  // R8: upper retry only answers an upper request
  a_r8_hi_retry_source: assert property (@(posedge clk) disable iff (rst)
    hi_retry |-> $past(hi_vld));
endmodule

bind dir_node dir_node_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lo_vld(lo_vld), .lo_op(lo_op), .hi_vld(hi_vld),
  .hi_op(hi_op), .up_vld(up_vld), .up_op(up_op), .dn_vld(dn_vld),
  .dn_op(dn_op), .lo_retry(lo_retry), .hi_retry(hi_retry)
);

// File: tb/dir_node_bench.sv
`timescale 1ns/1ps
module dir_node_bench;
  localparam int AW = 16;
  localparam logic [2:0] C_RD = 3'd1, C_ER = 3'd2, C_DT = 3'd3, C_AK = 3'd4, C_OU = 3'd5;
  localparam logic [2:0] C_NO = 3'd0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lo_vld = 1'b0, hi_vld = 1'b0;
  logic [2:0]    lo_op = '0, hi_op = '0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic          up_vld, dn_vld, lo_retry, hi_retry;
  logic [2:0]    up_op, dn_op;
  logic [AW-1:0] up_addr, dn_addr;

  always #5 clk = ~clk;

  dir_node #(.ADDR_W(AW), .LINE_BYTES(16), .SETS(4)) u_dir_node (
    .clk(clk), .rst(rst),
    .lo_vld(lo_vld), .lo_op(lo_op), .lo_addr(lo_addr),
    .hi_vld(hi_vld), .hi_op(hi_op), .hi_addr(hi_addr),
    .up_vld(up_vld), .up_op(up_op), .up_addr(up_addr),
    .dn_vld(dn_vld), .dn_op(dn_op), .dn_addr(dn_addr),
    .lo_retry(lo_retry), .hi_retry(hi_retry)
  );

  typedef struct {
    string         req;
    logic          uv;
    logic [2:0]    uo;
    logic [AW-1:0] ua;
    logic          dv;
    logic [2:0]    dop;
    logic [AW-1:0] da;
    logic          lr;
    logic          hr;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic step(string req,
                      bit hv, logic [2:0] ho, logic [AW-1:0] ha,
                      bit lv, logic [2:0] lop, logic [AW-1:0] la,
                      bit uv, logic [2:0] uo, logic [AW-1:0] ua,
                      bit dv, logic [2:0] dop, logic [AW-1:0] da,
                      bit lr, bit hr);
    exp_t e;
    @(negedge clk);
    hi_vld = hv; hi_op = ho; hi_addr = ha;
    lo_vld = lv; lo_op = lop; lo_addr = la;
    e.req = req; e.uv = uv; e.uo = uo; e.ua = ua;
    e.dv = dv; e.dop = dop; e.da = da; e.lr = lr; e.hr = hr;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per clock, shortly after the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic ok;
      e = q.pop_front();
      ok = (up_vld == e.uv) && (dn_vld == e.dv) &&
           (lo_retry == e.lr) && (hi_retry == e.hr) &&
           (!e.uv || (up_op == e.uo && up_addr == e.ua)) &&
           (!e.dv || (dn_op == e.dop && dn_addr == e.da));
      n_cmp++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: actual up=%0b/%0d/%h dn=%0b/%0d/%h lr=%0b hr=%0b expected up=%0b/%0d/%h dn=%0b/%0d/%h lr=%0b hr=%0b",
                 e.req, up_vld, up_op, up_addr, dn_vld, dn_op, dn_addr, lo_retry, hi_retry,
                 e.uv, e.uo, e.ua, e.dv, e.dop, e.da, e.lr, e.hr);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] LA = 16'h0100, LB = 16'h0200, LC = 16'h0300,
                            LD = 16'h0700, LX = 16'h0500, LY = 16'h0600;

  initial begin
    // R1: idle outputs through reset
    for (int i = 0; i < 3; i++)
      step("R1", 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    rst = 1'b0;
    // R1 R2: first read from below after reset goes up
    step("R2", 0, C_NO, 0, 1, C_RD, LA, 1, C_RD, LA, 0, C_NO, 0, 0, 0);
    step("R3", 0, C_NO, 0, 1, C_RD, LA, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R8", 0, C_NO, 0, 1, C_ER, LA, 0, C_NO, 0, 0, C_NO, 0, 1, 0);
    step("R4", 1, C_DT, LA, 0, C_NO, 0, 0, C_NO, 0, 1, C_DT, LA, 0, 0);
    step("R4", 0, C_NO, 0, 1, C_RD, LA, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R12", 1, C_DT, LA, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R6", 0, C_NO, 0, 1, C_ER, LA, 1, C_ER, LA, 0, C_NO, 0, 0, 0);
    step("R8", 0, C_NO, 0, 1, C_RD, LA, 0, C_NO, 0, 0, C_NO, 0, 1, 0);
    step("R8", 1, C_ER, LA, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 1);
    step("R6", 1, C_AK, LA, 0, C_NO, 0, 0, C_NO, 0, 1, C_AK, LA, 0, 0);
    step("R6", 0, C_NO, 0, 1, C_ER, LA, 0, C_NO, 0, 1, C_AK, LA, 0, 0);
    step("R5", 1, C_RD, LA, 0, C_NO, 0, 0, C_NO, 0, 1, C_RD, LA, 0, 0);
    step("R5", 0, C_NO, 0, 1, C_DT, LA, 1, C_DT, LA, 0, C_NO, 0, 0, 0);
    step("R5", 1, C_RD, LX, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R7", 1, C_ER, LA, 0, C_NO, 0, 0, C_NO, 0, 1, C_ER, LA, 0, 0);
    step("R7", 1, C_RD, LA, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R9", 1, C_RD, LY, 1, C_RD, LB, 0, C_NO, 0, 0, C_NO, 0, 1, 0);
    step("R9", 0, C_NO, 0, 1, C_RD, LB, 1, C_RD, LB, 0, C_NO, 0, 0, 0);
    step("R4", 1, C_DT, LB, 0, C_NO, 0, 0, C_NO, 0, 1, C_DT, LB, 0, 0);
    step("R11", 0, C_NO, 0, 1, C_RD, LC, 1, C_RD, LC, 0, C_NO, 0, 0, 0);
    step("R4", 1, C_DT, LC, 0, C_NO, 0, 0, C_NO, 0, 1, C_DT, LC, 0, 0);
    step("R11", 0, C_NO, 0, 1, C_RD, LB, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    // R10 R11: set full, way holding LC is older and gets pushed out
    step("R10", 0, C_NO, 0, 1, C_RD, LD, 1, C_OU, LC, 0, C_NO, 0, 1, 0);
    step("R10", 0, C_NO, 0, 1, C_RD, LD, 1, C_RD, LD, 0, C_NO, 0, 0, 0);
    step("R12", 1, C_AK, LB, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    step("R1", 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, C_NO, 0, 0, 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule